// File: doc/BRIEF.md
# Bus-Master DMA Channel Command and Status Registers

This block holds the software-visible control state for one channel of a bus-master disk DMA engine. Software reaches it through a byte-wide register port with two registers, a command register and a status register, chosen by a one-bit select. The command register starts and stops the engine and picks the transfer direction. The status register reports whether a transfer is active, whether the bus interface saw an abort, and whether the drive raised its interrupt. It also holds two drive-capability flags that only software uses.

The engine reports two events to the block: a done strobe when the final transfer of an end-of-table region finishes, and a strobe for a bus target or master abort. The drive's interrupt line enters asynchronously. It passes through a synchronizer and a rising-edge detector, so interrupt status is set by edges only and never by the line's level.

Stopping while a transfer is still active and before the drive has interrupted is an early stop. On an early stop the block sends the engine a one-cycle abort pulse, so that the engine drops pending drive data. A stopped transfer cannot be resumed.

Top module: `dmac_chan_regs`

## Requirements
- R1: After reset both registers read 00h, and `eng_go`, `eng_dir_wr`, `eng_abort` and `chan_irq` are 0.
- R2: Writing the command register (select 0) with bit 0 = 1 sets command bit 0 and `eng_go`, and sets status bit 0 (active) on the same clock edge. Writing command bit 0 = 0 clears command bit 0 and `eng_go`.
- R3: Command bit 3 (0 = engine reads, 1 = engine writes) drives `eng_dir_wr`. A command write updates it only when active was 0 before the write. While active is 1, writes to this bit are ignored.
- R4: Active is cleared on the edge where `eng_eot_done` is high, or where a command write has bit 0 = 0.
- R5: A command write with bit 0 = 0 while active = 1 and interrupt status = 0 gives `eng_abort` high for exactly the following cycle. Any other command write gives no pulse.
- R6: A rising edge of `drive_irq` sets status bit 2 (interrupt status). With the default two-stage synchronizer, the bit reads 1 after the third rising clock edge that samples the line high. Writing a 1 to status bit 2 clears it.
- R7: If status bit 2 is cleared while `drive_irq` is still high, it stays 0 until the line falls and then rises again.
- R8: A high `bus_abort` sets status bit 1 (error). Writing a 1 to status bit 1 clears it.
- R9: Status bits 6 and 5 are read/write flags with no effect on any output. Status bits 7, 4 and 3 and command bits 7:4 and 2:1 always read 0.
- R10: When a hardware set and a software clear hit the same flag on the same edge, the set wins. This applies to error, to interrupt status, and to a start write that coincides with `eng_eot_done`.
- R11: `chan_irq` always equals status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects command register, 1 selects status register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| eng_eot_done | input | 1 | Last transfer of an end-of-table region finished |
| bus_abort | input | 1 | Bus target or master abort seen by the engine |
| drive_irq | input | 1 | Asynchronous drive interrupt line |
| eng_go | output | 1 | Start/stop level to the engine |
| eng_dir_wr | output | 1 | Direction to the engine, 1 = write |
| eng_abort | output | 1 | One-cycle abort pulse on an early stop |
| chan_irq | output | 1 | Channel interrupt request level |

## Verification
The hardest situation to reach from the ports is clearing interrupt status while the drive line is still high. Because of the synchronizer delay, the clear must land after the edge has been registered but before the line drops. The stimulus therefore holds the line high, waits out the synchronizer latency, issues the write-1-clear, and keeps the line high for several more cycles. Only then does it release the line and raise it again. The coincident set-and-clear cases are placed with the same cycle counting.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int REG_W     = 8;
  localparam int CMD_START = 0;
  localparam int CMD_DIR   = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_INT    = 2;
  localparam int ST_CAP0   = 5;
  localparam int ST_CAP1   = 6;
  typedef enum logic {SEL_CMD = 1'b0, SEL_STAT = 1'b1} reg_sel_e;
endpackage

// File: rtl/dmac_rst_sync.sv
module dmac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= '0;
    else           sh_q <= sh_d;
  end

  assign rst_n_out = sh_q[STAGES-1];
endmodule

// File: rtl/dmac_irq_edge.sv
module dmac_irq_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_async,
  output logic irq_rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb sync_d = {sync_q[STAGES-2:0], irq_async};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign irq_rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dmac_cmd_reg.sv
module dmac_cmd_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic wr_start,
  input  logic wr_dir,
  input  logic active,
  output logic start_q,
  output logic dir_q
);
  logic start_en, dir_en;

  always_comb begin
    start_en = cmd_wr;
    dir_en   = cmd_wr & ~active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      if (start_en) start_q <= wr_start;
      if (dir_en)   dir_q   <= wr_dir;
    end
  end
endmodule

// File: rtl/dmac_stat_reg.sv
module dmac_stat_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic       stat_wr,
  input  logic       wr_start,
  input  logic       clr_err,
  input  logic       clr_int,
  input  logic [1:0] wr_cap,
  input  logic       eot_done,
  input  logic       bus_abort,
  input  logic       irq_rise,
  output logic       active_q,
  output logic       err_q,
  output logic       intst_q,
  output logic [1:0] cap_q,
  output logic       abort_q
);
  logic active_d, err_d, intst_d, abort_d;

  always_comb begin
    active_d = active_q;
    if (cmd_wr && wr_start)                  active_d = 1'b1;
    else if (eot_done || (cmd_wr && !wr_start)) active_d = 1'b0;

    err_d = err_q;
    if (bus_abort)                 err_d = 1'b1;
    else if (stat_wr && clr_err)   err_d = 1'b0;

    intst_d = intst_q;
    if (irq_rise)                  intst_d = 1'b1;
    else if (stat_wr && clr_int)   intst_d = 1'b0;

    abort_d = cmd_wr & ~wr_start & active_q & ~intst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
      intst_q  <= 1'b0;
      cap_q    <= '0;
      abort_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      err_q    <= err_d;
      intst_q  <= intst_d;
      abort_q  <= abort_d;
      if (stat_wr) cap_q <= wr_cap;
    end
  end
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             eng_eot_done,
  input  logic             bus_abort,
  input  logic             drive_irq,
  output logic             eng_go,
  output logic             eng_dir_wr,
  output logic             eng_abort,
  output logic             chan_irq
);
  logic       rst_sync_n;
  logic       cmd_wr, stat_wr, irq_rise;
  logic       start_q, dir_q, active_q, err_q, intst_q, abort_q;
  logic [1:0] cap_q;
  logic       unused_wdata;

  assign unused_wdata = ^{reg_wdata[7], reg_wdata[4]};

  dmac_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n));

  dmac_irq_edge #(.STAGES(SYNC_STAGES)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .irq_async(drive_irq), .irq_rise(irq_rise));

  always_comb begin
    cmd_wr  = reg_wr & (reg_sel == SEL_CMD);
    stat_wr = reg_wr & (reg_sel == SEL_STAT);
  end

  dmac_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_sync_n), .cmd_wr(cmd_wr),
    .wr_start(reg_wdata[CMD_START]), .wr_dir(reg_wdata[CMD_DIR]),
    .active(active_q), .start_q(start_q), .dir_q(dir_q));

  dmac_stat_reg u_stat (
    .clk(clk), .rst_n(rst_sync_n), .cmd_wr(cmd_wr), .stat_wr(stat_wr),
    .wr_start(reg_wdata[CMD_START]), .clr_err(reg_wdata[ST_ERR]),
    .clr_int(reg_wdata[ST_INT]), .wr_cap({reg_wdata[ST_CAP1], reg_wdata[ST_CAP0]}),
    .eot_done(eng_eot_done), .bus_abort(bus_abort), .irq_rise(irq_rise),
    .active_q(active_q), .err_q(err_q), .intst_q(intst_q), .cap_q(cap_q),
    .abort_q(abort_q));

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_CMD) begin
      reg_rdata[CMD_START] = start_q;
      reg_rdata[CMD_DIR]   = dir_q;
    end else begin
      reg_rdata[ST_ACT]  = active_q;
      reg_rdata[ST_ERR]  = err_q;
      reg_rdata[ST_INT]  = intst_q;
      reg_rdata[ST_CAP0] = cap_q[0];
      reg_rdata[ST_CAP1] = cap_q[1];
    end
  end

  assign eng_go     = start_q;
  assign eng_dir_wr = dir_q;
  assign eng_abort  = abort_q;
  assign chan_irq   = intst_q;
endmodule

// File: rtl/dmac_chan_regs_chk.sv
module dmac_chan_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_sel,
  input logic [7:0] reg_wdata,
  input logic       eng_eot_done,
  input logic       bus_abort,
  input logic       irq_rise,
  input logic       active_q,
  input logic       err_q,
  input logic       intst_q,
  input logic       eng_dir_wr,
  input logic       eng_abort
);
  assert_start_sets_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && !reg_sel && reg_wdata[0]) |-> active_q);

  assert_dir_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active_q) |-> $stable(eng_dir_wr));

  assert_eot_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_eot_done && !(reg_wr && !reg_sel && reg_wdata[0])) |-> !active_q);

  assert_abort_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> $past(reg_wr && !reg_sel && !reg_wdata[0] && active_q && !intst_q));

  assert_int_by_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intst_q) |-> $past(irq_rise));

  assert_err_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_abort) |-> err_q);
endmodule

bind dmac_chan_regs dmac_chan_regs_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .eng_eot_done(eng_eot_done), .bus_abort(bus_abort),
  .irq_rise(irq_rise), .active_q(active_q), .err_q(err_q), .intst_q(intst_q),
  .eng_dir_wr(eng_dir_wr), .eng_abort(eng_abort));

// File: tb/dmac_chan_regs_tb.sv
module dmac_chan_regs_tb;
  localparam int S = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_sel = 0, eot = 0, babort = 0, irq = 0;
  logic [7:0] wdata = 0, rdata;
  logic go, dirw, abrt, cirq;
  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_start, m_dir, m_act, m_err, m_int, m_abort;
  bit [1:0] m_cap;
  bit hist[8];

  always #5 clk = ~clk;

  dmac_chan_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(wdata), .reg_rdata(rdata), .eng_eot_done(eot),
    .bus_abort(babort), .drive_irq(irq), .eng_go(go), .eng_dir_wr(dirw),
    .eng_abort(abrt), .chan_irq(cirq));

  function automatic logic [7:0] exp_rd(bit sel);
    if (!sel) return {4'b0, m_dir, 2'b0, m_start};
    return {1'b0, m_cap, 2'b0, m_int, m_err, m_act};
  endfunction

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit cw, sw, rise, n_act, n_err, n_int;
    cw = reg_wr && !reg_sel;
    sw = reg_wr && reg_sel;
    rise = hist[S-1] && !hist[S];
    m_abort = cw && !wdata[0] && m_act && !m_int;
    if (cw && !m_act) m_dir = wdata[3];
    if (cw) m_start = wdata[0];
    n_act = (cw && wdata[0]) ? 1'b1 : (eot || (cw && !wdata[0])) ? 1'b0 : m_act;
    n_err = babort ? 1'b1 : (sw && wdata[1]) ? 1'b0 : m_err;
    n_int = rise ? 1'b1 : (sw && wdata[2]) ? 1'b0 : m_int;
    m_act = n_act; m_err = n_err; m_int = n_int;
    if (sw) m_cap = wdata[6:5];
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = irq;
  endtask

  // one cycle: drive at negedge, compare, then advance model at posedge
  task automatic cyc(bit w, bit sel, logic [7:0] d, bit e, bit b, bit i);
    @(negedge clk);
    reg_wr = w; reg_sel = sel; wdata = d; eot = e; babort = b; irq = i;
    #1;
    chk("rdata", rdata, exp_rd(sel));
    chk("eng_go", {7'b0, go}, {7'b0, m_start});
    chk("eng_dir_wr", {7'b0, dirw}, {7'b0, m_dir});
    chk("eng_abort", {7'b0, abrt}, {7'b0, m_abort});
    chk("chan_irq R11", {7'b0, cirq}, {7'b0, m_int});
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(int n, bit sel, bit i);
    for (int k = 0; k < n; k++) cyc(0, sel, 8'h00, 0, 0, i);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values of both registers and outputs
    cur_req = "R1";
    idle(3, 0, 0);
    idle(2, 1, 0);
    // R9: capability flags and reserved bits; w1c of clear flags is harmless
    cur_req = "R9";
    cyc(1, 1, 8'hFF, 0, 0, 0);
    idle(2, 1, 0);
    idle(1, 0, 0);
    // R2 + R3: start with direction write while idle
    cur_req = "R2";
    cyc(1, 0, 8'hFF, 0, 0, 0);
    idle(1, 0, 0);
    idle(1, 1, 0);
    cur_req = "R3";
    cyc(1, 0, 8'h01, 0, 0, 0);
    idle(2, 0, 0);
    // R4: end-of-table completion clears active, no abort
    cur_req = "R4";
    cyc(0, 1, 8'h00, 1, 0, 0);
    idle(2, 1, 0);
    cur_req = "R3";
    cyc(1, 0, 8'h00, 0, 0, 0);
    idle(2, 0, 0);
    // R5: early stop aborts
    cur_req = "R5";
    cyc(1, 0, 8'h09, 0, 0, 0);
    cyc(1, 0, 8'h00, 0, 0, 0);
    idle(3, 1, 0);
    cyc(1, 0, 8'h00, 0, 0, 0);
    idle(2, 0, 0);
    // R6: drive interrupt edge sets status, with latency
    cur_req = "R6";
    cyc(1, 0, 8'h01, 0, 0, 0);
    for (int k = 0; k < 5; k++) cyc(0, 1, 8'h00, 0, 0, 1);
    cur_req = "R5";
    cyc(1, 0, 8'h00, 0, 0, 1);
    idle(2, 1, 1);
    // R7: clear while line still high stays clear
    cur_req = "R7";
    cyc(1, 1, 8'h04, 0, 0, 1);
    idle(6, 1, 1);
    idle(3, 1, 0);
    cur_req = "R6";
    idle(5, 1, 1);
    cyc(1, 1, 8'h04, 0, 0, 1);
    idle(2, 1, 0);
    // R8: bus abort sets error, w1c clears
    cur_req = "R8";
    cyc(0, 1, 8'h00, 0, 1, 0);
    idle(1, 1, 0);
    cyc(1, 1, 8'h02, 0, 0, 0);
    idle(1, 1, 0);
    // R10: coincident set and clear
    cur_req = "R10";
    cyc(0, 1, 8'h00, 0, 1, 0);
    cyc(1, 1, 8'h02, 0, 1, 0);
    idle(2, 1, 0);
    cyc(1, 1, 8'h02, 0, 0, 0);
    cyc(1, 0, 8'h01, 1, 0, 0);
    idle(2, 1, 0);
    // interrupt edge landing on a w1c of interrupt status
    cyc(0, 1, 8'h00, 0, 0, 1);
    cyc(0, 1, 8'h00, 0, 0, 1);
    cyc(1, 1, 8'h04, 0, 0, 1);
    idle(3, 1, 1);
    cur_req = "R11";
    idle(2, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule